// File: doc/BRIEF.md
# Circular Interrupt Vector Queue Writer

This block collects 32-bit interrupt vectors from several internal event sources and stores them, one at a time, into a circular queue that lives in host memory. It drives a single-word write master port: each vector becomes one word write at the queue's current slot. The slot pointer then moves on by one word and folds back to the start of the queue when it would run past the end. After every completed memory write the host receives a one-cycle interrupt pulse.

The queue is described by a base address and a length in bytes. Both are loaded by a one-cycle definition strobe, which also places the slot pointer back at the base. Until a non-zero base has been defined, the queue counts as absent: requests are still taken so that sources do not stall, but they are flagged as dropped and nothing reaches memory. When several sources ask in the same cycle, a fixed priority picks the lowest-numbered one. By convention source 0 carries action acknowledges, ahead of the per-channel event sources. Every vector written has its top bit forced high so that the host can tell filled slots from empty ones.

Top module: `ivq_writer`

## Requirements
- R1: Bit 31 of every word written to memory is 1, and bits 30:0 equal bits 30:0 of the vector the winning source supplied.
- R2: While the stored base address is zero, a request is still accepted but `post_dropped` pulses in the same cycle, and no memory write and no host interrupt follow from it.
- R3: Each accepted, non-dropped vector goes to the current slot address, and the next slot is that address plus 4.
- R4: When the current address plus 4 is equal to or greater than base plus length, the next slot is the base address again.
- R5: A definition strobe loads base and length and sets the current slot to the new base, so the next vector written after it lands at the new base.
- R6: Among simultaneous requests the lowest-numbered requester is accepted first, and at most one bit of `post_accept` is high in any cycle.
- R7: `post_accept` is combinational from the requests while the block is idle. Each post is acknowledged by exactly one single-cycle accept pulse to its own requester, and no accept is given while a write is outstanding.
- R8: `host_irq` is high for exactly one cycle, in the cycle right after each write handshake (`mem_wr_valid` and `mem_wr_ready` both high at a clock edge).
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, the valid, address and data outputs hold their values into the next cycle.
- R10: After reset no write is pending, `host_irq` is low, and the base is zero, so a first post before any definition is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qdef_valid | input | 1 | One-cycle strobe that loads a new queue definition |
| qdef_base | input | AW | Byte address of the queue start (word aligned) |
| qdef_len | input | AW | Queue length in bytes (multiple of 4) |
| post_req | input | NSRC | Per-source request, held until accepted |
| post_vec | input | 32*NSRC | Per-source vectors, source i in bits 32*i+31 down to 32*i |
| post_accept | output | NSRC | One-cycle accept pulse to the winning source |
| post_dropped | output | 1 | Pulses with an accept when no queue is defined |
| mem_wr_valid | output | 1 | Memory word-write request |
| mem_wr_addr | output | AW | Byte address of the word write |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_ready | input | 1 | Memory accepts the write at this edge |
| host_irq | output | 1 | One-cycle pulse after each completed write |

## Verification
The bench builds the block with three sources and a 12-bit address. This keeps every slot address small enough to predict by hand. The bench sweeps every queue length from one to six words, both with an always-ready memory and with a memory that stalls two cycles out of three. Each length gets more than two full passes, so every wrap position and every stall alignment is covered. Simultaneous request masks test the priority order, and definitions with a zero base test the dropped path, both straight after reset and in the middle of a run.

// File: rtl/ivq_pkg.sv
package ivq_pkg;
  localparam int VEC_W     = 32;
  localparam int VALID_BIT = 31;
  localparam int WORD_B    = 4;

  // vector bit positions used by the sources
  localparam int B_ACT_ACK  = 15;
  localparam int B_ACT_FAIL = 14;
  localparam int B_HOST     = 13;
  localparam int B_FRAME    = 12;
  localparam int B_IDLE_CHG = 11;
  localparam int B_SHORT    = 10;
  localparam int B_ERROR    = 9;
  localparam int B_OVF      = 8;
  localparam int B_DIR      = 5;

  typedef enum logic {ST_IDLE = 1'b0, ST_WRITE = 1'b1} wr_state_t;
endpackage

// File: rtl/ivq_prio_arb.sv
module ivq_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_lane
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/ivq_ring_ptr.sv
module ivq_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          def_valid,
  input  logic [AW-1:0] def_base,
  input  logic [AW-1:0] def_len,
  input  logic          step,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] cur_o
);
  import ivq_pkg::*;

  logic [AW-1:0] base_q, len_q, cur_q;
  logic [AW-1:0] base_d, len_d, cur_d;
  logic [AW:0]   inc_sum, limit;
  logic          en;

  always_comb begin
    inc_sum = {1'b0, cur_q} + (AW+1)'(WORD_B);
    limit   = {1'b0, base_q} + {1'b0, len_q};
    base_d  = base_q;
    len_d   = len_q;
    cur_d   = cur_q;
    en      = 1'b0;
    if (def_valid) begin
      base_d = def_base;
      len_d  = def_len;
      cur_d  = def_base;
      en     = 1'b1;
    end else if (step) begin
      cur_d  = (inc_sum >= limit) ? base_q : inc_sum[AW-1:0];
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cur_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      len_q  <= len_d;
      cur_q  <= cur_d;
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/ivq_write_eng.sv
module ivq_write_eng #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gnt,
  input  logic [31:0]   sel_vec,
  input  logic          no_queue,
  input  logic [AW-1:0] slot_addr,
  input  logic          wr_ready,
  output logic [N-1:0]  accept,
  output logic          dropped,
  output logic          reserve,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          irq
);
  import ivq_pkg::*;

  wr_state_t     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic          irq_q, irq_d;
  logic          idle, any, hshake;

  always_comb begin
    idle    = (state_q == ST_IDLE);
    any     = |gnt;
    accept  = idle ? gnt : '0;
    dropped = idle & any & no_queue;
    reserve = idle & any & ~no_queue;
    hshake  = ~idle & wr_ready;
    irq_d   = hshake;
    state_d = state_q;
    if (reserve)     state_d = ST_WRITE;
    else if (hshake) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (reserve) begin
      addr_q <= slot_addr;
      data_q <= sel_vec | (32'd1 << VALID_BIT);
    end
  end

  assign wr_valid = ~idle;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign irq      = irq_q;
endmodule

// File: rtl/ivq_writer.sv
module ivq_writer #(
  parameter int NSRC = 4,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qdef_valid,
  input  logic [AW-1:0]     qdef_base,
  input  logic [AW-1:0]     qdef_len,
  input  logic [NSRC-1:0]   post_req,
  input  logic [32*NSRC-1:0] post_vec,
  output logic [NSRC-1:0]   post_accept,
  output logic              post_dropped,
  output logic              mem_wr_valid,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              host_irq
);
  logic [NSRC-1:0] gnt;
  logic [31:0]     sel_vec;
  logic [AW-1:0]   base_w, cur_w;
  logic            reserve;

  ivq_prio_arb #(.N(NSRC)) u_arb (.req(post_req), .gnt(gnt));

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (gnt[i]) sel_vec = sel_vec | post_vec[32*i +: 32];
  end

  ivq_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .def_valid(qdef_valid), .def_base(qdef_base), .def_len(qdef_len),
    .step(reserve), .base_o(base_w), .cur_o(cur_w)
  );

  ivq_write_eng #(.N(NSRC), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .gnt(gnt), .sel_vec(sel_vec), .no_queue(base_w == '0),
    .slot_addr(cur_w), .wr_ready(mem_wr_ready),
    .accept(post_accept), .dropped(post_dropped), .reserve(reserve),
    .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .irq(host_irq)
  );
endmodule

// File: rtl/ivq_writer_chk.sv
module ivq_writer_chk #(
  parameter int NSRC = 4,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] post_accept,
  input logic            post_dropped,
  input logic            mem_wr_valid,
  input logic [AW-1:0]   mem_wr_addr,
  input logic [31:0]     mem_wr_data,
  input logic            mem_wr_ready,
  input logic            host_irq
);
  a_r6_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_accept));
  a_r1_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_data[31]);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready) |=> host_irq);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
  a_r2_drop_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
    post_dropped |-> (|post_accept));
  a_r2_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    post_dropped |=> !mem_wr_valid);
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (post_accept == '0));
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr[1:0] == 2'b00));
endmodule

bind ivq_writer ivq_writer_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_accept(post_accept),
  .post_dropped(post_dropped), .mem_wr_valid(mem_wr_valid),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_ready(mem_wr_ready), .host_irq(host_irq)
);

// File: tb/sim_ivq_writer.sv
`timescale 1ns/1ps
module sim_ivq_writer;
  localparam int NS = 3;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic qdef_valid;
  logic [AW-1:0] qdef_base, qdef_len;
  logic [NS-1:0] post_req;
  logic [32*NS-1:0] post_vec;
  logic [NS-1:0] post_accept;
  logic post_dropped, mem_wr_valid, mem_wr_ready, host_irq;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  always #2.5 clk = ~clk;

  ivq_writer #(.NSRC(NS), .AW(AW)) u0 (.*);

  int total = 0, bad = 0;
  int cyc = 0, stall = 0;
  int wr_cnt = 0, exp_cnt = 0, irq_cnt = 0;
  logic [AW-1:0] e_addr [256];
  logic [31:0]   e_data [256];
  int            e_tag  [256];
  logic [AW-1:0] m_base, m_len, m_cur;
  bit            m_fresh;
  bit            hs_prev = 0, st_prev = 0;
  logic [AW-1:0] a_prev;
  logic [31:0]   d_prev;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory ready driver
  always @(negedge clk) begin
    cyc++;
    mem_wr_ready = (stall != 0) ? (cyc % 3 == 2) : 1'b1;
  end

  // write/irq monitor
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hs_prev || host_irq)
        chk(host_irq == hs_prev, "R8", {31'd0, host_irq}, {31'd0, hs_prev});
      if (st_prev)
        chk(mem_wr_valid && mem_wr_addr == a_prev && mem_wr_data == d_prev,
            "R9", {20'd0, mem_wr_addr}, {20'd0, a_prev});
      if (host_irq) irq_cnt++;
      if (mem_wr_valid && mem_wr_ready) begin
        if (wr_cnt >= exp_cnt) chk(0, "R2", wr_cnt, exp_cnt);
        else begin
          chk(mem_wr_data == e_data[wr_cnt], "R1", mem_wr_data, e_data[wr_cnt]);
          case (e_tag[wr_cnt])
            4: chk(mem_wr_addr == e_addr[wr_cnt], "R4", mem_wr_addr, e_addr[wr_cnt]);
            5: chk(mem_wr_addr == e_addr[wr_cnt], "R5", mem_wr_addr, e_addr[wr_cnt]);
            default: chk(mem_wr_addr == e_addr[wr_cnt], "R3", mem_wr_addr, e_addr[wr_cnt]);
          endcase
        end
        wr_cnt++;
      end
      hs_prev = mem_wr_valid && mem_wr_ready;
      st_prev = mem_wr_valid && !mem_wr_ready;
      a_prev  = mem_wr_addr;
      d_prev  = mem_wr_data;
    end
  end

  task automatic define_q(input logic [AW-1:0] b, input logic [AW-1:0] l);
    @(negedge clk);
    qdef_valid = 1'b1; qdef_base = b; qdef_len = l;
    @(negedge clk);
    qdef_valid = 1'b0;
    m_base = b; m_len = l; m_cur = b; m_fresh = 1;
  endtask

  task automatic post(input logic [NS-1:0] mask, input logic [31:0] v0,
                      input logic [31:0] v1, input logic [31:0] v2);
    logic [NS-1:0] pend, got, want;
    int guard, src;
    pend = mask;
    @(negedge clk);
    post_vec = {v2, v1, v0};
    post_req = mask;
    guard = 0;
    while (pend != 0 && guard < 200) begin
      #1;
      got = post_accept;
      if (got != 0) begin
        want = pend & (~pend + 1'b1);
        chk(got == want, "R6", {29'd0, got}, {29'd0, want});
        chk((got & ~pend) == 0, "R7", {29'd0, got}, {29'd0, pend});
        src = got[0] ? 0 : (got[1] ? 1 : 2);
        chk(post_dropped == (m_base == 0), "R2", {31'd0, post_dropped}, {31'd0, m_base == 0});
        if (m_base != 0) begin
          e_data[exp_cnt] = post_vec[32*src +: 32] | 32'h8000_0000;
          e_addr[exp_cnt] = m_cur;
          e_tag[exp_cnt]  = m_fresh ? 5 : ((m_cur == m_base && exp_cnt > 0) ? 4 : 3);
          exp_cnt++;
          m_fresh = 0;
          m_cur = ((32'(m_cur) + 4) >= (32'(m_base) + 32'(m_len))) ? m_base : m_cur + 12'd4;
        end
        pend = pend & ~got;
      end
      @(negedge clk);
      post_req = post_req & ~got;
      guard++;
    end
    post_req = '0;
    guard = 0;
    while ((wr_cnt != exp_cnt || mem_wr_valid) && guard < 50) begin
      @(negedge clk); guard++;
    end
    chk(wr_cnt == exp_cnt, "R7", wr_cnt, exp_cnt);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; qdef_valid = 0; qdef_base = 0; qdef_len = 0;
    post_req = 0; post_vec = 0; mem_wr_ready = 1;
    m_base = 0; m_len = 0; m_cur = 0; m_fresh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_wr_valid && !host_irq && post_accept == 0, "R10",
        {30'd0, mem_wr_valid, host_irq}, 0);

    // first post before any definition is dropped
    begin
      int w0, i0;
      w0 = wr_cnt; i0 = irq_cnt;
      post(3'b010, 0, (32'd1 << 12) | 32'd7, 0);
      chk(wr_cnt == w0 && irq_cnt == i0, "R10", wr_cnt - w0, 0);
    end

    for (int st = 0; st < 2; st++) begin
      stall = st;
      for (int lw = 1; lw <= 6; lw++) begin
        define_q(12'h100 + 12'(lw * 64), 12'(lw * 4));
        for (int k = 0; k < 2 * lw + 1; k++)
          post(3'b001 << (k % 3), 32'd1 << 15,
               (32'd1 << 12) | 32'(k), 32'hF0F0_0000 ^ 32'(k * 32'h0101_0013));
      end
      // simultaneous requests: priority order
      define_q(12'h800, 12'd16);
      post(3'b111, 32'd1 << 15, (32'd1 << 12) | 32'd3, (32'd1 << 9) | (32'd1 << 5));
      post(3'b110, 0, (32'd1 << 10) | 32'd1, 32'hFFFF_FFFF);
      post(3'b101, (32'd1 << 14), 0, (32'd1 << 8) | 32'd2);
    end

    // base zero mid-run: dropped, nothing written
    stall = 0;
    define_q(12'h000, 12'd16);
    begin
      int w0, i0;
      w0 = wr_cnt; i0 = irq_cnt;
      post(3'b111, 32'd1 << 15, 32'd1 << 11, 32'd1 << 13);
      chk(wr_cnt == w0 && irq_cnt == i0, "R2", wr_cnt - w0, 0);
    end
    // redefinition restarts at the new base
    define_q(12'h300, 12'd8);
    post(3'b100, 0, 0, 32'h0000_0055);
    define_q(12'h340, 12'd8);
    post(3'b001, 32'h7FFF_FFFF, 0, 0);

    chk(irq_cnt == wr_cnt, "R8", irq_cnt, wr_cnt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule